// File: doc/BRIEF.md
# Strobed Output Port with Interrupt

This block is an 8-bit output port that passes a byte written by a host to an external device. It uses a buffer-full / acknowledge handshake. When the host writes, the byte is latched and driven on the port pins without a break. An active-low buffer-full line then tells the device that fresh data is waiting. The device takes the byte and pulses its active-low acknowledge line. When that line returns high, the port marks its buffer as empty. If the port's interrupt enable is set, it also raises an interrupt request, so that the host can supply the next byte.

The acknowledge line comes from outside the clock domain. It passes through a synchroniser of configurable depth before its rising edge is detected. With interrupts off, the host learns that the buffer is empty by polling a status byte, which holds the buffer-full line, the enable and the request.

Top module: `strobed_out_port`

## Requirements
- R1: On a cycle with `wr_i` high, `pdata_o` takes `wdata_i` at that clock edge. Without a write, `pdata_o` holds its value.
- R2: A host write drives `obf_no` low at the same edge. A write while `obf_no` is already low replaces the latched byte and keeps `obf_no` low.
- R3: A rising edge on `ack_ni` drives `obf_no` high on the third clock edge after the change: two synchroniser flops, then the edge register. A falling edge on `ack_ni` changes nothing.
- R4: When the detected acknowledge rise finds the interrupt enable set, `intr_o` goes high together with `obf_no`. When the enable is clear, `intr_o` stays low.
- R5: A host write clears `intr_o` at the same edge. When a write and an acknowledge rise take effect on the same edge, the write wins: `obf_no` low, `intr_o` low, new byte latched.
- R6: On a cycle with `inte_wr_i` high, the interrupt enable takes `inte_val_i`. Changing the enable does not itself change `intr_o`.
- R7: `status_o` holds the buffer-full line in bit 0, the interrupt enable in bit 1 and the interrupt request in bit 2. Bits 7 to 3 read as zero.
- R8: After reset, `obf_no` is high, `intr_o` is low, the enable is clear and `pdata_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Host write strobe for the data byte |
| wdata_i | input | 8 | Host write data |
| inte_wr_i | input | 1 | Host write strobe for the interrupt enable |
| inte_val_i | input | 1 | New interrupt enable value |
| status_o | output | 8 | Status byte: buffer-full, enable, request |
| intr_o | output | 1 | Interrupt request to the host |
| pdata_o | output | 8 | Latched data on the port pins |
| obf_no | output | 1 | Buffer full, active low |
| ack_ni | input | 1 | Device acknowledge, active low |

## Verification
The bench builds the block with its defaults: an 8-bit data path and a two-flop synchroniser. This fixes the acknowledge-to-empty delay at three edges, and the bench samples just before and just after that edge. Random interleavings of writes, acknowledge pulses and enable changes exercise the handshake state. Directed cases cover three further conditions: a write landing on the same edge as the detected acknowledge, a rewrite while the buffer is still full, and a falling acknowledge with no effect.

// File: rtl/sop_pkg.sv
package sop_pkg;
  localparam int unsigned STAT_W       = 8;
  localparam int unsigned STAT_OBF_BIT = 0;
  localparam int unsigned STAT_IE_BIT  = 1;
  localparam int unsigned STAT_IRQ_BIT = 2;

  typedef struct packed {
    logic obf_n;
    logic inte;
    logic intr;
  } hs_state_t;

  function automatic logic [STAT_W-1:0] pack_status(hs_state_t s);
    logic [STAT_W-1:0] v;
    v = '0;
    v[STAT_OBF_BIT] = s.obf_n;
    v[STAT_IE_BIT]  = s.inte;
    v[STAT_IRQ_BIT] = s.intr;
    return v;
  endfunction
endpackage

// File: rtl/sop_sync.sv
module sop_sync #(
  parameter int unsigned STAGES    = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= RESET_VAL;
        else         chain_q[g] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q[g] <= RESET_VAL;
        else         chain_q[g] <= chain_q[g-1];
      end
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sop_edge.sv
module sop_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic rise_o
);
  logic prev_q;

  // Idle level is high, so reset to high to avoid a false edge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R3
endmodule

// File: rtl/sop_hshk.sv
module sop_hshk #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              inte_wr_i,
  input  logic              inte_val_i,
  input  logic              ack_rise_i,
  output logic [DATA_W-1:0] data_o,
  output sop_pkg::hs_state_t st_o
);
  logic [DATA_W-1:0] data_q;
  logic              obf_nq, inte_q, intr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) data_q <= '0;
    else if (wr_i) data_q <= wdata_i;
  end

  // Write has priority over a coincident acknowledge.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      obf_nq <= 1'b1;
      intr_q <= 1'b0;
    end else if (wr_i) begin
      obf_nq <= 1'b0;
      intr_q <= 1'b0;
    end else if (ack_rise_i) begin
      obf_nq <= 1'b1;
      if (inte_q) intr_q <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        inte_q <= 1'b0;
    else if (inte_wr_i) inte_q <= inte_val_i;
  end

  assign data_o   = data_q;
  assign st_o.obf_n = obf_nq;
  assign st_o.inte  = inte_q;
  assign st_o.intr  = intr_q;

  AST_WR_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> data_q == $past(wdata_i)); // R1
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(data_q)); // R1
  AST_WR_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !obf_nq); // R2
  AST_ACK_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rise_i && !wr_i) |=> obf_nq); // R3
  AST_IRQ_ON_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_rise_i && !wr_i && inte_q) |=> intr_q); // R4
  AST_IRQ_NEEDS_IE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(intr_q) |-> $past(inte_q)); // R4
  AST_WR_CLR_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> !intr_q); // R5
  AST_IE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inte_wr_i |=> inte_q == $past(inte_val_i)); // R6
  AST_IE_NO_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !ack_rise_i) |=> $stable(intr_q)); // R6
endmodule

// File: rtl/strobed_out_port.sv
module strobed_out_port #(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_i,
  input  logic [DATA_W-1:0]          wdata_i,
  input  logic                       inte_wr_i,
  input  logic                       inte_val_i,
  output logic [sop_pkg::STAT_W-1:0] status_o,
  output logic                       intr_o,
  output logic [DATA_W-1:0]          pdata_o,
  output logic                       obf_no,
  input  logic                       ack_ni
);
  logic               ack_s;
  logic               ack_rise;
  sop_pkg::hs_state_t st;

  sop_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (ack_ni),
    .q_o   (ack_s)
  );

  sop_edge i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (ack_s),
    .rise_o(ack_rise)
  );

  sop_hshk #(.DATA_W(DATA_W)) i_hshk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wdata_i   (wdata_i),
    .inte_wr_i (inte_wr_i),
    .inte_val_i(inte_val_i),
    .ack_rise_i(ack_rise),
    .data_o    (pdata_o),
    .st_o      (st)
  );

  assign obf_no   = st.obf_n;
  assign intr_o   = st.intr;
  assign status_o = sop_pkg::pack_status(st);

  AST_STATUS_MAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[sop_pkg::STAT_OBF_BIT] == obf_no && status_o[sop_pkg::STAT_IRQ_BIT] == intr_o); // R7
  AST_FALL_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && !ack_rise && !obf_no) |=> !obf_no); // R3
endmodule

// File: tb/test_strobed_out_port.sv
`timescale 1ns/1ps
module test_strobed_out_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic       inte_wr_i = 1'b0;
  logic       inte_val_i = 1'b0;
  logic [7:0] status_o;
  logic       intr_o;
  logic [7:0] pdata_o;
  logic       obf_no;
  logic       ack_ni = 1'b1;

  int vectors = 0;
  int miscompares = 0;

  logic [7:0] m_data;
  logic       m_obf_n, m_inte, m_intr;

  always #5 clk_i = ~clk_i;

  strobed_out_port i_strobed_out_port (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(wr_i), .wdata_i(wdata_i),
    .inte_wr_i(inte_wr_i), .inte_val_i(inte_val_i), .status_o(status_o),
    .intr_o(intr_o), .pdata_o(pdata_o), .obf_no(obf_no), .ack_ni(ack_ni)
  );

  function automatic logic [7:0] exp_status(logic ob, logic ie, logic ir);
    return {5'b0, ir, ie, ob};
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    chk(pdata_o, m_data, {req, " R1 data"});
    chk({7'b0, obf_no}, {7'b0, m_obf_n}, {req, " R2/R3 obf"});
    chk({7'b0, intr_o}, {7'b0, m_intr}, {req, " R4/R5 intr"});
    chk(status_o, exp_status(m_obf_n, m_inte, m_intr), {req, " R7 status"});
  endtask

  task automatic do_write(input logic [7:0] d);
    @(negedge clk_i);
    wr_i = 1'b1; wdata_i = d;
    @(negedge clk_i);
    wr_i = 1'b0;
    m_data = d; m_obf_n = 1'b0; m_intr = 1'b0;
  endtask

  task automatic do_inte(input logic v);
    @(negedge clk_i);
    inte_wr_i = 1'b1; inte_val_i = v;
    @(negedge clk_i);
    inte_wr_i = 1'b0;
    m_inte = v;
  endtask

  // Full acknowledge pulse with the timing checks of R3.
  task automatic do_ack(input int low_cycles);
    @(negedge clk_i);
    ack_ni = 1'b0;
    for (int i = 0; i < low_cycles + 3; i++) @(negedge clk_i);
    check_all("R3 falling ack ignored");
    ack_ni = 1'b1;
    @(posedge clk_i); @(posedge clk_i);
    @(negedge clk_i);
    check_all("R3 before third edge");
    @(posedge clk_i);
    @(negedge clk_i);
    m_obf_n = 1'b1;
    if (m_inte) m_intr = 1'b1;
    check_all("R3/R4 after third edge");
  endtask

  initial begin
    #2_000_000;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    void'($urandom(32'h5A17));
    m_data = '0; m_obf_n = 1'b1; m_inte = 1'b0; m_intr = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R8 reset");

    // R2 rewrite while full
    do_write(8'hA5);
    check_all("R2 first write");
    do_write(8'h3C);
    check_all("R2 rewrite while full");

    // R4 disabled: polling sees empty via status
    do_ack(2);
    chk(status_o, 8'h01, "R4 poll with inte clear");

    // R6 enable then interrupt
    do_inte(1'b1);
    check_all("R6 enable set");
    do_write(8'h81);
    do_ack(1);
    chk({7'b0, intr_o}, 8'h01, "R4 intr raised");
    do_inte(1'b0);
    check_all("R6 disable keeps intr");
    do_write(8'h00);
    check_all("R5 write clears intr");

    // R5 write coincides with detected rise
    do_inte(1'b1);
    @(negedge clk_i); ack_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    ack_ni = 1'b1;
    @(posedge clk_i); @(posedge clk_i);
    @(negedge clk_i);
    wr_i = 1'b1; wdata_i = 8'h5E;
    @(negedge clk_i);
    wr_i = 1'b0;
    m_data = 8'h5E; m_obf_n = 1'b0; m_intr = 1'b0;
    check_all("R5 write wins over ack");

    for (int n = 0; n < 400; n++) begin
      case ($urandom % 4)
        0: do_write(8'($urandom));
        1: do_ack(int'($urandom % 4));
        2: do_inte(1'($urandom));
        default: @(negedge clk_i);
      endcase
      check_all("random");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule